// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block is a small word-addressed memory shared by several requesters. It serves exactly one request per cycle and carries out each request as one indivisible step. Besides plain reads and writes it offers an exchange operation, a conditional exchange that compares against an expected value, and a reserve/conditional-store pair for optimistic update loops.

Each requester presents a valid bit, a 3-bit operation code, an address, a compare value and a write value. A fixed-priority arbiter picks one requester and the memory operation runs in that cycle. The following cycle brings a registered response: the requester index, the word's contents before the operation and a success flag.

Every requester has a reservation register, made of a valid bit and an address. A reserving read sets it. Several events clear it: the same requester's other accesses, a context-switch input for that requester, or a successful write to the reserved address by any other requester. A conditional store succeeds only while its requester's reservation is intact and names the same address.

Top module: `atomic_mem_unit`

## Requirements
- R1: At most one requester is granted per cycle. When any request is valid, the lowest-numbered valid requester gets the grant, and the grant vector is one-hot over the valid requests.
- R2: A grant in cycle t gives `rsp_vld` high in cycle t+1 with `rsp_id` equal to the granted index. A cycle with no valid request gives `rsp_vld` low in the next cycle.
- R3: Operation codes are: 0 read, 1 write, 2 exchange, 3 compare-exchange, 4 reserving read, 5 conditional store. Codes 6 and 7 act as a read. A read returns the word and leaves memory unchanged. A write stores the write value. Both report `rsp_ok` = 1, and every response carries the word's prior contents in `rsp_data`.
- R4: An exchange stores the write value and returns the prior contents, with `rsp_ok` = 1.
- R5: A compare-exchange whose compare value equals the word stores the write value and returns `rsp_ok` = 1 with the prior contents.
- R6: A compare-exchange whose compare value differs leaves the word unchanged and returns `rsp_ok` = 0 with the current contents.
- R7: A reserving read returns the word and records a reservation on that address for the requester. A following conditional store by the same requester to that address, with the reservation still valid, stores the write value and returns `rsp_ok` = 1.
- R8: After reset no reservation exists. A conditional store with no valid reservation, or with one on a different address, returns `rsp_ok` = 0 and leaves memory unchanged.
- R9: A read, write, exchange or compare-exchange by a requester clears that requester's own reservation.
- R10: A context-switch input high for a requester in cycle t clears its reservation from cycle t+1 onward. A conditional store granted in cycle t still sees the old reservation.
- R11: A successful write to an address by any requester (write, exchange, successful compare-exchange or successful conditional store) clears every other requester's reservation on that address. Reservations on other addresses are unaffected.
- R12: A conditional store always clears its own requester's reservation, whether it succeeds or fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears memory, reservations and response |
| req_vld | input | N_REQ | Request valid per requester |
| req_op | input | 3*N_REQ | Operation code per requester, requester i in bits [3i+2:3i] |
| req_addr | input | ADDR_W*N_REQ | Word address per requester |
| req_cmp | input | DATA_W*N_REQ | Compare value per requester |
| req_new | input | DATA_W*N_REQ | Write value per requester |
| ctx_sw | input | N_REQ | Context-switch indication per requester; drops its reservation |
| gnt | output | N_REQ | Combinational one-hot grant for the current cycle |
| rsp_vld | output | 1 | Response valid, one cycle after the grant |
| rsp_id | output | clog2(N_REQ) | Index of the requester being answered |
| rsp_data | output | DATA_W | Word contents before the operation |
| rsp_ok | output | 1 | Success flag (compare and conditional-store outcome; 1 for other operations) |

## Verification
The hardest case to reach is a conditional store that fails only because of an event that happened between its reserving read and the store. Examples are another requester's successful write to the same word, a write to a different word that must not break it, a context switch, or the requester's own read in the middle. Directed sequences build each of these interleavings one cycle at a time. A long random phase then confines addresses to four words, often sets the compare value equal to the live word, and raises context switches sparsely. This makes reservations, collisions and successful compare-exchanges frequent, and every response is checked against a reference model kept in the bench.

// File: rtl/amu_pkg.sv
package amu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_XCHG  = 3'd2,
        OP_CMPX  = 3'd3,
        OP_RSV   = 3'd4,
        OP_CST   = 3'd5
    } amu_op_e;

    // outcome of one granted operation
    typedef struct packed {
        logic wr;
        logic ok;
    } amu_act_t;

    function automatic amu_act_t decide(input logic [OP_W-1:0] op,
                                        input logic            cmp_eq,
                                        input logic            rsv_hit);
        amu_act_t a;
        unique case (op)
            OP_WRITE, OP_XCHG: begin a.wr = 1'b1;    a.ok = 1'b1;    end
            OP_CMPX:           begin a.wr = cmp_eq;  a.ok = cmp_eq;  end
            OP_CST:            begin a.wr = rsv_hit; a.ok = rsv_hit; end
            default:           begin a.wr = 1'b0;    a.ok = 1'b1;    end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/amu_arbiter.sv
module amu_arbiter #(
    parameter  int N_REQ = 4,
    localparam int IDW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt,
    output logic [IDW-1:0]   gnt_id,
    output logic             any
);
    always_comb begin
        gnt    = '0;
        gnt_id = '0;
        any    = 1'b0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                gnt_id = IDW'(i);
                any    = 1'b1;
            end
        end
    end

    assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt & ~req) == '0));

    assert_gnt_when_req_R1: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt));
endmodule

// File: rtl/amu_resv.sv
module amu_resv
    import amu_pkg::*;
#(
    parameter  int N_REQ  = 4,
    parameter  int ADDR_W = 4,
    localparam int IDW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [IDW-1:0]    gid,
    input  logic [OP_W-1:0]   op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_done,
    input  logic [N_REQ-1:0]  ctx_sw,
    output logic              rsv_hit
);
    logic [N_REQ-1:0]             rv, rv_n;
    logic [N_REQ-1:0][ADDR_W-1:0] ra, ra_n;

    assign rsv_hit = rv[gid] && (ra[gid] == addr);

    always_comb begin
        rv_n = rv;
        ra_n = ra;
        for (int i = 0; i < N_REQ; i++) begin
            if (go && (gid == IDW'(i))) begin
                if (op == OP_RSV) begin
                    rv_n[i] = 1'b1;
                    ra_n[i] = addr;
                end else begin
                    rv_n[i] = 1'b0;
                end
            end else if (wr_done && rv[i] && (ra[i] == addr)) begin
                rv_n[i] = 1'b0;
            end
            if (ctx_sw[i]) rv_n[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rv <= '0;
            ra <= '0;
        end else begin
            rv <= rv_n;
            ra <= ra_n;
        end
    end

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rv == '0));

    assert_cst_drops_own_R12: assert property (@(posedge clk) disable iff (rst)
        (go && op == OP_CST) |=> !rv[$past(gid)]);

    for (genvar g = 0; g < N_REQ; g++) begin : g_chk
        assert_ctx_clear_R10: assert property (@(posedge clk) disable iff (rst)
            ctx_sw[g] |=> !rv[g]);
    end
endmodule

// File: rtl/amu_store.sv
module amu_store
    import amu_pkg::*;
#(
    parameter  int ADDR_W = 4,
    parameter  int DATA_W = 16,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [OP_W-1:0]   op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] cmp,
    input  logic [DATA_W-1:0] wval,
    input  logic              rsv_hit,
    output logic [DATA_W-1:0] word,
    output logic              wr_done,
    output logic              ok
);
    logic [DEPTH-1:0][DATA_W-1:0] mem;
    amu_act_t act;

    assign word    = mem[addr];
    assign act     = decide(op, word == cmp, rsv_hit);
    assign wr_done = go && act.wr;
    assign ok      = act.ok;

    always_ff @(posedge clk) begin
        if (rst) mem <= '0;
        else if (wr_done) mem[addr] <= wval;
    end

    assert_cmpx_miss_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (go && op == OP_CMPX && word != cmp) |=> (mem[$past(addr)] == $past(word)));

    assert_xchg_stores_R4: assert property (@(posedge clk) disable iff (rst)
        (go && op == OP_XCHG) |=> (mem[$past(addr)] == $past(wval)));

    assert_cst_fail_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (go && op == OP_CST && !rsv_hit) |=> (mem[$past(addr)] == $past(word)));
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
    import amu_pkg::*;
#(
    parameter  int N_REQ  = 4,
    parameter  int ADDR_W = 4,
    parameter  int DATA_W = 16,
    localparam int IDW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_REQ-1:0]         req_vld,
    input  logic [OP_W*N_REQ-1:0]    req_op,
    input  logic [ADDR_W*N_REQ-1:0]  req_addr,
    input  logic [DATA_W*N_REQ-1:0]  req_cmp,
    input  logic [DATA_W*N_REQ-1:0]  req_new,
    input  logic [N_REQ-1:0]         ctx_sw,
    output logic [N_REQ-1:0]         gnt,
    output logic                     rsp_vld,
    output logic [IDW-1:0]           rsp_id,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     rsp_ok
);
    logic              any;
    logic [IDW-1:0]    gid;
    logic [OP_W-1:0]   s_op;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_cmp, s_new, word;
    logic              rsv_hit, wr_done, ok;

    assign s_op   = req_op[gid*OP_W +: OP_W];
    assign s_addr = req_addr[gid*ADDR_W +: ADDR_W];
    assign s_cmp  = req_cmp[gid*DATA_W +: DATA_W];
    assign s_new  = req_new[gid*DATA_W +: DATA_W];

    amu_arbiter #(.N_REQ(N_REQ)) u_arb (
        .clk(clk), .rst(rst), .req(req_vld), .gnt(gnt), .gnt_id(gid), .any(any)
    );

    amu_resv #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) u_resv (
        .clk(clk), .rst(rst), .go(any), .gid(gid), .op(s_op), .addr(s_addr),
        .wr_done(wr_done), .ctx_sw(ctx_sw), .rsv_hit(rsv_hit)
    );

    amu_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .go(any), .op(s_op), .addr(s_addr), .cmp(s_cmp),
        .wval(s_new), .rsv_hit(rsv_hit), .word(word), .wr_done(wr_done), .ok(ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            rsp_id   <= '0;
            rsp_data <= '0;
            rsp_ok   <= 1'b0;
        end else begin
            rsp_vld  <= any;
            rsp_id   <= gid;
            rsp_data <= word;
            rsp_ok   <= ok;
        end
    end

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (|req_vld) |=> (rsp_vld && rsp_id == $past(gid)));

    assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !(|req_vld) |=> !rsp_vld);
endmodule

// File: tb/test_atomic_mem_unit.sv
`timescale 1ns/1ps
module test_atomic_mem_unit;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]    req_vld = '0;
    logic [2:0]      op_q [N];
    logic [AW-1:0]   ad_q [N];
    logic [DW-1:0]   cm_q [N];
    logic [DW-1:0]   nw_q [N];
    logic [N-1:0]    ctx = '0;
    logic [3*N-1:0]  req_op;
    logic [AW*N-1:0] req_addr;
    logic [DW*N-1:0] req_cmp, req_new;
    logic [N-1:0]    gnt;
    logic            rsp_vld, rsp_ok;
    logic [1:0]      rsp_id;
    logic [DW-1:0]   rsp_data;

    assign req_op   = {op_q[3], op_q[2], op_q[1], op_q[0]};
    assign req_addr = {ad_q[3], ad_q[2], ad_q[1], ad_q[0]};
    assign req_cmp  = {cm_q[3], cm_q[2], cm_q[1], cm_q[0]};
    assign req_new  = {nw_q[3], nw_q[2], nw_q[1], nw_q[0]};

    atomic_mem_unit #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) i_atomic_mem_unit (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_op(req_op), .req_addr(req_addr),
        .req_cmp(req_cmp), .req_new(req_new), .ctx_sw(ctx), .gnt(gnt),
        .rsp_vld(rsp_vld), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
    );

    int checks = 0;
    int fails  = 0;

    // reference state
    logic [DW-1:0] mem_m [1<<AW];
    logic          rv_m  [N];
    logic [AW-1:0] ra_m  [N];

    task automatic chk(input logic c, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!c) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, check grant, advance one cycle, check response
    task automatic step(input string tag);
        int g;
        logic [N-1:0] eg;
        logic [AW-1:0] a;
        logic [DW-1:0] w;
        logic [2:0] o;
        logic wr, ok;
        g = -1;
        for (int i = N - 1; i >= 0; i--) if (req_vld[i]) g = i;
        eg = (g >= 0) ? (N'(1) << g) : '0;
        #1;
        chk(gnt == eg, {tag, " R1 gnt"}, 32'(gnt), 32'(eg));
        w = '0; ok = 1'b0; a = '0;
        if (g >= 0) begin
            a = ad_q[g]; w = mem_m[a]; o = op_q[g];
            case (o)
                3'd1, 3'd2: begin wr = 1'b1; ok = 1'b1; end
                3'd3: begin wr = (w == cm_q[g]); ok = wr; end
                3'd5: begin wr = rv_m[g] && (ra_m[g] == a); ok = wr; end
                default: begin wr = 1'b0; ok = 1'b1; end
            endcase
            if (wr) mem_m[a] = nw_q[g];
            for (int i = 0; i < N; i++) begin
                if (i == g) begin
                    if (o == 3'd4) begin rv_m[i] = 1'b1; ra_m[i] = a; end
                    else rv_m[i] = 1'b0;
                end else if (wr && rv_m[i] && ra_m[i] == a) rv_m[i] = 1'b0;
            end
        end
        for (int i = 0; i < N; i++) if (ctx[i]) rv_m[i] = 1'b0;
        @(negedge clk);
        chk(rsp_vld == (g >= 0), {tag, " R2 vld"}, 32'(rsp_vld), 32'(g >= 0));
        if (g >= 0) begin
            chk(rsp_id == 2'(g), {tag, " R2 id"}, 32'(rsp_id), 32'(g));
            chk(rsp_data == w, {tag, " data"}, 32'(rsp_data), 32'(w));
            chk(rsp_ok == ok, {tag, " ok"}, 32'(rsp_ok), 32'(ok));
        end
    endtask

    task automatic clr();
        req_vld = '0; ctx = '0;
        for (int i = 0; i < N; i++) begin op_q[i] = '0; ad_q[i] = '0; cm_q[i] = '0; nw_q[i] = '0; end
    endtask

    task automatic one(input int id, input logic [2:0] o, input logic [AW-1:0] a,
                       input logic [DW-1:0] c, input logic [DW-1:0] n, input string tag);
        clr();
        req_vld[id] = 1'b1; op_q[id] = o; ad_q[id] = a; cm_q[id] = c; nw_q[id] = n;
        step(tag);
    endtask

    bit done = 1'b0;
    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clr();
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
        for (int i = 0; i < N; i++) begin rv_m[i] = 1'b0; ra_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_vld == 1'b0, "reset R2 rsp_vld", 32'(rsp_vld), 0);
        chk(gnt == '0, "reset R1 gnt", 32'(gnt), 0);

        one(0, 3'd5, 4'd1, 0, 16'h5, "cst_no_rsv_R8");
        chk(rsp_ok == 1'b0, "cst_no_rsv_R8 explicit", 32'(rsp_ok), 0);
        one(0, 3'd0, 4'd1, 0, 0, "read_after_fail_R8");
        one(1, 3'd1, 4'd2, 0, 16'h1234, "write_R3");
        one(1, 3'd6, 4'd2, 0, 0, "code6_read_R3");
        chk(rsp_data == 16'h1234, "code6_read_R3 explicit", 32'(rsp_data), 32'h1234);
        one(2, 3'd2, 4'd2, 0, 16'hBEEF, "xchg_R4");
        chk(rsp_data == 16'h1234, "xchg_R4 explicit", 32'(rsp_data), 32'h1234);
        one(3, 3'd3, 4'd2, 16'hBEEF, 16'h7, "cmpx_hit_R5");
        chk(rsp_ok == 1'b1, "cmpx_hit_R5 explicit", 32'(rsp_ok), 1);
        one(3, 3'd3, 4'd2, 16'hBEEF, 16'h9, "cmpx_miss_R6");
        chk(rsp_data == 16'h7 && !rsp_ok, "cmpx_miss_R6 explicit", 32'(rsp_data), 32'h7);
        one(0, 3'd0, 4'd2, 0, 0, "after_miss_R6");
        chk(rsp_data == 16'h7, "after_miss_R6 explicit", 32'(rsp_data), 32'h7);

        one(0, 3'd4, 4'd3, 0, 0, "rsv_R7");
        one(0, 3'd5, 4'd3, 0, 16'd11, "cst_ok_R7");
        chk(rsp_ok == 1'b1, "cst_ok_R7 explicit", 32'(rsp_ok), 1);
        one(0, 3'd5, 4'd3, 0, 16'd12, "cst_again_R12");
        chk(rsp_ok == 1'b0, "cst_again_R12 explicit", 32'(rsp_ok), 0);

        one(1, 3'd4, 4'd4, 0, 0, "rsv_R9");
        one(1, 3'd0, 4'd5, 0, 0, "own_read_R9");
        one(1, 3'd5, 4'd4, 0, 16'd1, "cst_after_read_R9");
        chk(rsp_ok == 1'b0, "cst_after_read_R9 explicit", 32'(rsp_ok), 0);

        one(2, 3'd4, 4'd4, 0, 0, "rsv_R10");
        clr(); ctx[2] = 1'b1; step("ctx_R10");
        one(2, 3'd5, 4'd4, 0, 16'd2, "cst_after_ctx_R10");
        chk(rsp_ok == 1'b0, "cst_after_ctx_R10 explicit", 32'(rsp_ok), 0);

        one(0, 3'd4, 4'd6, 0, 0, "rsv0_R11");
        one(1, 3'd4, 4'd7, 0, 0, "rsv1_R11");
        one(3, 3'd1, 4'd6, 0, 16'd33, "other_write_R11");
        one(1, 3'd5, 4'd7, 0, 16'd44, "cst_untouched_R11");
        chk(rsp_ok == 1'b1, "cst_untouched_R11 explicit", 32'(rsp_ok), 1);
        one(0, 3'd5, 4'd6, 0, 16'd55, "cst_broken_R11");
        chk(rsp_ok == 1'b0, "cst_broken_R11 explicit", 32'(rsp_ok), 0);

        one(2, 3'd4, 4'd8, 0, 0, "rsv_other_R8");
        one(2, 3'd5, 4'd9, 0, 16'd3, "cst_wrong_addr_R8");
        chk(rsp_ok == 1'b0, "cst_wrong_addr_R8 explicit", 32'(rsp_ok), 0);

        clr();
        req_vld = 4'b1110;
        for (int i = 0; i < N; i++) begin op_q[i] = 3'd0; ad_q[i] = 4'd2; end
        step("prio_R1");
        chk(rsp_id == 2'd1, "prio_R1 explicit", 32'(rsp_id), 1);
        req_vld = 4'b1100; step("prio2_R1");
        clr(); step("idle_R2");

        void'($urandom(32'd2024));
        for (int k = 0; k < 3000; k++) begin
            clr();
            for (int i = 0; i < N; i++) begin
                req_vld[i] = ($urandom % 2) == 0;
                op_q[i] = 3'($urandom % 8);
                ad_q[i] = AW'($urandom % 4);
                cm_q[i] = (($urandom % 2) == 0) ? mem_m[ad_q[i]] : DW'($urandom % 4);
                nw_q[i] = DW'($urandom);
                ctx[i]  = ($urandom % 16) == 0;
            end
            step("random R3 R4 R5 R6 R7 R9 R10 R11 R12");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule